// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries data words from a write clock domain to a read clock domain that has no fixed phase or frequency relation to it. Storage is an internal array of `2**ADDR_W` words, so the depth is always a power of two. The FIFO generates its own memory addresses. Each side keeps a binary pointer and a Gray-coded pointer, both one bit wider than the address. The Gray pointer crosses to the other side through a flop chain of `SYNC_STAGES` stages. Both domains have their own active-low asynchronous reset.

Each side runs a small flag state machine that is recomputed on every clock of its domain from the side's next pointer and the synchronized pointer of the other side. The write side has three states. In Open no flag is raised. In Near only almost-full is raised. In Full both flags are raised. Its transitions are fill-reaches-margin (Open→Near), pointer-collision (any→Full), drain-below-margin (Near→Open) and space-freed (Full→Near/Open). The read side has three states. In Empty both flags are raised. In Low only almost-empty is raised. In Avail no flag is raised. Its transitions are pointer-match (any→Empty), data-arrives (Empty→Low/Avail), fill-exceeds-margin (Low→Avail) and fill-drops-to-margin (Avail→Low). The almost-full and almost-empty margins are parameters. A `FALL_THROUGH` parameter selects between a registered read port and a combinational read port that shows the head word.

Top module: `dual_clock_fifo`

## Requirements
- R1: When the write reset is released, `wr_full` and `wr_almost_full` are 0. When the read reset is released, `rd_empty` and `rd_almost_empty` are 1, and in registered mode `rd_data` is 0.
- R2: Every accepted word is read out exactly once, in the order in which it was written. A write is accepted when `wr_en`=1 while `wr_full`=0. A read is accepted when `rd_en`=1 while `rd_empty`=0. An accepted write advances the write pointer by exactly one.
- R3: `wr_full` is 1 whenever 2**ADDR_W words are held. Once both pointers have crossed, it equals (held == 2**ADDR_W). It rises only on the write clock edge that follows an accepted write.
- R4: `rd_empty` is 1 whenever no word is held. Once the pointers have crossed, it equals (held == 0). It rises only on the read clock edge that follows an accepted read.
- R5: `wr_almost_full` is 1 whenever the number of held words is at least 2**ADDR_W − AF_MARGIN. Once the pointers have crossed, it equals that comparison.
- R6: `rd_almost_empty` is 1 whenever the number of held words is at most AE_MARGIN. Once the pointers have crossed, it equals that comparison.
- R7: A write attempted while `wr_full`=1 changes neither the write pointer nor any stored word.
- R8: A read attempted while `rd_empty`=1 changes neither the read pointer nor `rd_data` in registered mode.
- R9: In registered mode (`FALL_THROUGH`=0), `rd_data` takes the head word on the read clock edge that accepts a read. It holds its value on every other edge.
- R10: In fall-through mode (`FALL_THROUGH`=1), `rd_data` shows the head word without a clock whenever `rd_empty`=0. All four flags behave the same in both modes.
- R11: R3 to R6 still hold after the pointers have wrapped past 2·2**ADDR_W. The threshold arithmetic is done modulo 2**(ADDR_W+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot remains |
| wr_almost_full | output | 1 | Free slots are at or below AF_MARGIN |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Head word (registered or direct, set by FALL_THROUGH) |
| rd_empty | output | 1 | No word is held |
| rd_almost_empty | output | 1 | Held words are at or below AE_MARGIN |

## Verification
The bench drives the FIFO into a full state and then keeps writing, so a design that wrote while full would overwrite the oldest unread word and return it corrupted. It reads past empty, where a read pointer that still moved would replay stale words or shift the registered output. It fills and drains one word at a time over three passes so that both pointers wrap. A threshold compared at address width instead of pointer width would show the almost flags wrong at exactly these points. A long phase with random enables, first biased toward writing and then toward reading, compares every read word and every flag bound against a queue model. The registered and fall-through instances run side by side, so a read port that shows the wrong word or uses the wrong latency in either mode is caught.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    // Write side flag states
    typedef enum logic [1:0] {
        WS_OPEN = 2'd0,
        WS_NEAR = 2'd1,
        WS_FULL = 2'd2
    } wr_state_e;

    // Read side flag states
    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_LOW   = 2'd1,
        RS_AVAIL = 2'd2
    } rd_state_e;

    // Binary to reflected Gray code (callers cast to their own width)
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= '0;
            end
        end else begin
            chain[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/dcfifo_store.sv
`timescale 1ns/1ps
module dcfifo_store #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int FALL_THROUGH = 0,
    localparam int DEPTH       = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              w_push,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [DATA_W-1:0] w_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              r_pop,
    input  logic [ADDR_W-1:0] r_addr,
    output logic [DATA_W-1:0] r_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (w_push) begin
            mem[w_addr] <= w_data;
        end
    end

    generate
        if (FALL_THROUGH != 0) begin : g_direct
            // Head word is visible without a clock
            assign r_data = mem[r_addr];
        end else begin : g_registered
            logic [DATA_W-1:0] out_q;
            always_ff @(posedge rd_clk or negedge rd_rst_n) begin
                if (!rd_rst_n) begin
                    out_q <= '0;
                end else if (r_pop) begin
                    out_q <= mem[r_addr];
                end
            end
            assign r_data = out_q;
        end
    endgenerate

endmodule

// File: rtl/dcfifo_wr_side.sv
`timescale 1ns/1ps
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int AF_MARGIN = 1,
    localparam int PTR_W    = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rq_gray,
    output logic [PTR_W-1:0]  w_bin,
    output logic [PTR_W-1:0]  w_gray,
    output logic [ADDR_W-1:0] w_addr,
    output logic              w_push,
    output logic              full,
    output logic              almost_full
);

    localparam int DEPTH = 1 << ADDR_W;
    // Threshold sized to the pointer width before any compare
    localparam logic [PTR_W-1:0] AF_LIMIT = PTR_W'(DEPTH - AF_MARGIN);

    wr_state_e        state_q, state_nx;
    logic [PTR_W-1:0] bin_q, gray_q;
    logic [PTR_W-1:0] bin_nx, gray_nx, rq_bin, fill_nx, collide_pat;
    logic             hit_full, hit_near;

    // Pointer arithmetic and threshold tests
    always_comb begin
        w_push      = wr_en && (state_q != WS_FULL);
        bin_nx      = bin_q + PTR_W'(w_push);
        gray_nx     = PTR_W'(to_gray(32'(bin_nx)));
        rq_bin      = PTR_W'(from_gray(32'(rq_gray)));
        fill_nx     = bin_nx - rq_bin;
        collide_pat = {~rq_gray[PTR_W-1:PTR_W-2], rq_gray[PTR_W-3:0]};
        hit_full    = (gray_nx == collide_pat);
        hit_near    = (fill_nx >= AF_LIMIT);
    end

    // Transitions: pointer-collision, fill-reaches-margin, drain-below-margin, space-freed
    always_comb begin
        if (hit_full) begin
            state_nx = WS_FULL;
        end else if (hit_near) begin
            state_nx = WS_NEAR;
        end else begin
            state_nx = WS_OPEN;
        end
    end

    // State and pointer registers
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            state_q <= WS_OPEN;
            bin_q   <= '0;
            gray_q  <= '0;
        end else begin
            state_q <= state_nx;
            bin_q   <= bin_nx;
            gray_q  <= gray_nx;
        end
    end

    // Flag decode
    always_comb begin
        full        = 1'b0;
        almost_full = 1'b0;
        unique case (state_q)
            WS_OPEN: ;
            WS_NEAR: almost_full = 1'b1;
            WS_FULL: begin
                full        = 1'b1;
                almost_full = 1'b1;
            end
            default: ;
        endcase
    end

    assign w_bin  = bin_q;
    assign w_gray = gray_q;
    assign w_addr = bin_q[ADDR_W-1:0];

endmodule

// File: rtl/dcfifo_rd_side.sv
`timescale 1ns/1ps
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int AE_MARGIN = 1,
    localparam int PTR_W    = ADDR_W + 1
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wq_gray,
    output logic [PTR_W-1:0]  r_bin,
    output logic [PTR_W-1:0]  r_gray,
    output logic [ADDR_W-1:0] r_addr,
    output logic              r_pop,
    output logic              empty,
    output logic              almost_empty
);

    localparam logic [PTR_W-1:0] AE_LIMIT = PTR_W'(AE_MARGIN);

    rd_state_e        state_q, state_nx;
    logic [PTR_W-1:0] bin_q, gray_q;
    logic [PTR_W-1:0] bin_nx, gray_nx, wq_bin, fill_nx;
    logic             hit_empty, hit_low;

    always_comb begin
        r_pop     = rd_en && (state_q != RS_EMPTY);
        bin_nx    = bin_q + PTR_W'(r_pop);
        gray_nx   = PTR_W'(to_gray(32'(bin_nx)));
        wq_bin    = PTR_W'(from_gray(32'(wq_gray)));
        fill_nx   = wq_bin - bin_nx;
        hit_empty = (gray_nx == wq_gray);
        hit_low   = (fill_nx <= AE_LIMIT);
    end

    // Transitions: pointer-match, data-arrives, fill-exceeds-margin, fill-drops-to-margin
    always_comb begin
        if (hit_empty) begin
            state_nx = RS_EMPTY;
        end else if (hit_low) begin
            state_nx = RS_LOW;
        end else begin
            state_nx = RS_AVAIL;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            state_q <= RS_EMPTY;
            bin_q   <= '0;
            gray_q  <= '0;
        end else begin
            state_q <= state_nx;
            bin_q   <= bin_nx;
            gray_q  <= gray_nx;
        end
    end

    always_comb begin
        empty        = 1'b0;
        almost_empty = 1'b0;
        unique case (state_q)
            RS_EMPTY: begin
                empty        = 1'b1;
                almost_empty = 1'b1;
            end
            RS_LOW:   almost_empty = 1'b1;
            RS_AVAIL: ;
            default:  ;
        endcase
    end

    assign r_bin  = bin_q;
    assign r_gray = gray_q;
    assign r_addr = bin_q[ADDR_W-1:0];

endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int FALL_THROUGH = 0,
    parameter int AF_MARGIN    = 1,
    parameter int AE_MARGIN    = 1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_almost_empty
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PTR_W-1:0]  rq_gray, wq_gray;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic              w_push, r_pop;

    dcfifo_wr_side #(
        .ADDR_W    (ADDR_W),
        .AF_MARGIN (AF_MARGIN)
    ) u_wr_side (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_en       (wr_en),
        .rq_gray     (rq_gray),
        .w_bin       (wr_bin),
        .w_gray      (wr_gray),
        .w_addr      (w_addr),
        .w_push      (w_push),
        .full        (wr_full),
        .almost_full (wr_almost_full)
    );

    dcfifo_rd_side #(
        .ADDR_W    (ADDR_W),
        .AE_MARGIN (AE_MARGIN)
    ) u_rd_side (
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_en        (rd_en),
        .wq_gray      (wq_gray),
        .r_bin        (rd_bin),
        .r_gray       (rd_gray),
        .r_addr       (r_addr),
        .r_pop        (r_pop),
        .empty        (rd_empty),
        .almost_empty (rd_almost_empty)
    );

    // Read pointer into the write domain
    dcfifo_sync #(
        .WIDTH  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d_in  (rd_gray),
        .d_out (rq_gray)
    );

    // Write pointer into the read domain
    dcfifo_sync #(
        .WIDTH  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (wr_gray),
        .d_out (wq_gray)
    );

    dcfifo_store #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .FALL_THROUGH (FALL_THROUGH)
    ) u_store (
        .wr_clk   (wr_clk),
        .w_push   (w_push),
        .w_addr   (w_addr),
        .w_data   (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .r_pop    (r_pop),
        .r_addr   (r_addr),
        .r_data   (rd_data)
    );

endmodule

// File: rtl/dual_clock_fifo_checker.sv
`timescale 1ns/1ps
module dual_clock_fifo_checker #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int FALL_THROUGH = 0,
    localparam int PTR_W       = ADDR_W + 1
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_full,
    input logic [PTR_W-1:0]  wr_bin,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [PTR_W-1:0]  rd_bin,
    input logic [DATA_W-1:0] rd_data
);

    assert_push_step_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !wr_full) |=> (wr_bin == $past(wr_bin) + PTR_W'(1)));

    assert_full_after_write_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_full) |-> $past(wr_en));

    assert_empty_after_read_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_empty) |-> $past(rd_en));

    assert_no_overflow_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_full) |=> $stable(wr_bin));

    assert_no_underflow_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && rd_empty) |=> $stable(rd_bin));

    generate
        if (FALL_THROUGH == 0) begin : g_reg_checks
            assert_data_hold_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
                !(rd_en && !rd_empty) |=> $stable(rd_data));
        end
    endgenerate

endmodule

bind dual_clock_fifo dual_clock_fifo_checker #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .FALL_THROUGH (FALL_THROUGH)
) u_checker (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .wr_bin   (wr_bin),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_empty (rd_empty),
    .rd_bin   (rd_bin),
    .rd_data  (rd_data)
);

// File: tb/dual_clock_fifo_tb.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int AFM   = 2;
    localparam int AEM   = 2;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n, wr_en, rd_en;
    logic [DW-1:0] wr_data;
    logic          full_a, afull_a, empty_a, aempty_a;
    logic          full_b, afull_b, empty_b, aempty_b;
    logic [DW-1:0] rdata_a, rdata_b;

    always #4 wr_clk = ~wr_clk;   // 125 MHz
    always #7 rd_clk = ~rd_clk;   // unrelated, slower

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .FALL_THROUGH(0),
                      .AF_MARGIN(AFM), .AE_MARGIN(AEM), .SYNC_STAGES(2)) u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(full_a), .wr_almost_full(afull_a),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rdata_a),
        .rd_empty(empty_a), .rd_almost_empty(aempty_a));

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .FALL_THROUGH(1),
                      .AF_MARGIN(AFM), .AE_MARGIN(AEM), .SYNC_STAGES(2)) u_dut_ft (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(full_b), .wr_almost_full(afull_b),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rdata_b),
        .rd_empty(empty_b), .rd_almost_empty(aempty_b));

    logic [DW-1:0] model_q[$];
    logic [DW-1:0] exp_reg;
    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic w_bounds();
        check(full_a == full_b && afull_a == afull_b, "R10", "write flags differ by mode",
              int'({full_b, afull_b}), int'({full_a, afull_a}));
        if (model_q.size() == DEPTH)
            check(full_a == 1'b1, "R3", "full with depth words held", int'(full_a), 1);
        if (model_q.size() >= DEPTH - AFM)
            check(afull_a == 1'b1, "R5", "almost-full at margin", int'(afull_a), 1);
    endtask

    task automatic r_bounds();
        check(empty_a == empty_b && aempty_a == aempty_b, "R10", "read flags differ by mode",
              int'({empty_b, aempty_b}), int'({empty_a, aempty_a}));
        if (model_q.size() == 0)
            check(empty_a == 1'b1, "R4", "empty with nothing held", int'(empty_a), 1);
        if (model_q.size() <= AEM)
            check(aempty_a == 1'b1, "R6", "almost-empty at margin", int'(aempty_a), 1);
        check(rdata_a == exp_reg, "R2 R9", "registered read data", int'(rdata_a), int'(exp_reg));
    endtask

    task automatic wcycle(input bit en, input logic [DW-1:0] d);
        bit acc;
        @(negedge wr_clk);
        w_bounds();
        wr_en   = en;
        wr_data = d;
        acc     = en && !full_a;
        @(posedge wr_clk);
        if (acc) model_q.push_back(d);
    endtask

    task automatic rcycle(input bit en);
        bit acc;
        @(negedge rd_clk);
        r_bounds();
        rd_en = en;
        acc   = en && !empty_a;
        if (acc) begin
            check(model_q.size() > 0, "R2", "read accepted with nothing held",
                  model_q.size(), 1);
            if (model_q.size() > 0)
                check(rdata_b == model_q[0], "R10", "fall-through head word",
                      int'(rdata_b), int'(model_q[0]));
        end
        @(posedge rd_clk);
        if (acc && model_q.size() > 0) exp_reg = model_q.pop_front();
    endtask

    task automatic settle();
        fork
            begin repeat (8) wcycle(1'b0, '0); end
            begin repeat (8) rcycle(1'b0); end
        join
    endtask

    task automatic exact(input string extra);
        int n;
        @(negedge wr_clk);
        n = model_q.size();
        check(full_a == (n == DEPTH), {"R3", extra}, "settled full", int'(full_a), int'(n == DEPTH));
        check(afull_a == (n >= DEPTH - AFM), {"R5", extra}, "settled almost-full",
              int'(afull_a), int'(n >= DEPTH - AFM));
        @(negedge rd_clk);
        n = model_q.size();
        check(empty_a == (n == 0), {"R4", extra}, "settled empty", int'(empty_a), int'(n == 0));
        check(aempty_a == (n <= AEM), {"R6", extra}, "settled almost-empty",
              int'(aempty_a), int'(n <= AEM));
    endtask

    initial begin
        logic [DW-1:0] seq;
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0; exp_reg = '0;
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;

        // R1 reset state
        @(negedge wr_clk);
        check(!full_a && !afull_a && !full_b && !afull_b, "R1", "write flags after reset",
              int'({full_a, afull_a}), 0);
        @(negedge rd_clk);
        check(empty_a && aempty_a && empty_b && aempty_b, "R1", "read flags after reset",
              int'({empty_a, aempty_a}), 3);
        check(rdata_a == '0, "R1", "registered data after reset", int'(rdata_a), 0);

        seq = 8'd1;
        for (int round = 0; round < 3; round++) begin
            string tag = (round > 0) ? " R11" : "";
            for (int k = 0; k < DEPTH; k++) begin
                wcycle(1'b1, seq);
                seq++;
                wcycle(1'b0, '0);
                settle();
                exact(tag);
            end
            // R7: writes while full must be dropped
            repeat (3) wcycle(1'b1, 8'hEE);
            wcycle(1'b0, '0);
            settle();
            check(full_a == 1'b1, "R7", "still full after dropped writes", int'(full_a), 1);
            exact(tag);
            for (int k = 0; k < DEPTH; k++) begin
                rcycle(1'b1);
                rcycle(1'b0);
                settle();
                exact(tag);
            end
            // R8: reads while empty must be dropped
            repeat (3) rcycle(1'b1);
            rcycle(1'b0);
            @(negedge rd_clk);
            check(rdata_a == exp_reg, "R8", "data after empty reads", int'(rdata_a), int'(exp_reg));
            check(empty_a == 1'b1, "R8", "still empty after dropped reads", int'(empty_a), 1);
        end

        // Random traffic: first write-heavy, then read-heavy
        fork
            begin
                for (int i = 0; i < 1500; i++)
                    wcycle(($urandom % 4) < ((i < 750) ? 3 : 1), 8'($urandom));
                wcycle(1'b0, '0);
            end
            begin
                for (int i = 0; i < 900; i++)
                    rcycle(($urandom % 4) < ((i < 450) ? 1 : 3));
                rcycle(1'b0);
            end
        join
        for (int i = 0; i < 200 && model_q.size() > 0; i++) rcycle(1'b1);
        rcycle(1'b0);
        settle();
        exact(" R11");
        check(model_q.size() == 0, "R2", "all words returned", model_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wr_clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule